// File: doc/BRIEF.md
# Sum of Absolute Differences Engine

This block compares two equal-length arrays of unsigned pixels, as used in video block matching where a 16x16 block is handled as a flat list of 256 bytes. A pulse or level on `go` starts a comparison. The engine then walks a shared index over both arrays and adds the magnitude of each pixel difference to a running total. When the walk ends, the total is published on `sad`.

Both arrays sit in memories outside the block. They share one address bus and return data in the same cycle as the address. The schedule alternates a bound-check cycle with an accumulate cycle, so each element costs two cycles. The result register changes only at the end of a comparison, and a one-cycle `done` pulse marks that moment.

Top module: `sad_engine`

## Requirements
- R1: After reset, `sad` is 0 and `done` and `rd` are low.
- R2: While idle with `go` low, `rd` and `done` stay low and `sad` keeps its value.
- R3: A comparison asserts `rd` exactly once per element, never in two adjacent cycles, and with `addr` running 0, 1, 2, … in ascending order; `addr` bit 8 is always 0 while `rd` is high.
- R4: The published result equals the sum over all elements of |a - b|, with both elements treated as unsigned 8-bit values. This holds whichever operand is larger.
- R5: `done` is high for exactly one cycle, in the 515th cycle after the clock edge that samples `go` high in idle. That count is 1 initialization cycle, 512 loop cycles for 256 elements, 1 final check cycle and 1 finish cycle.
- R6: `sad` keeps the previous result through the `done` cycle. It takes the new result on the clock edge that ends that cycle and holds it until the next `done`.
- R7: If `go` is high on the return to idle, the next comparison starts at once, and the next `done` comes 516 cycles after the previous one.
- R8: Changes on `go` during a comparison have no effect on its timing or result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request, sampled in idle |
| addr | output | 9 | Shared element index for both memories |
| rd | output | 1 | Read strobe, high in accumulate cycles |
| a_data | input | 8 | Element of the first array at `addr` |
| b_data | input | 8 | Element of the second array at `addr` |
| sad | output | 32 | Result register |
| done | output | 1 | One-cycle pulse in the finish cycle |

## Verification
The bench builds the engine with its default values: 256 elements of 8 bits and a 32-bit sum. With these values the full 515-cycle latency and the 516-cycle back-to-back period can be checked directly. They also reach the largest possible total of 65280 in both directions of subtraction. Scoreboard cases cover all-zero arrays, both saturated orderings, a crossing ramp and random data. Further cases hold `go` high across two runs and toggle `go` during a run.

// File: rtl/sad_engine.sv
module sad_engine #(
  parameter int N_ELEM = 256,
  parameter int PIX_W  = 8,
  parameter int SUM_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         go,
  output logic [$clog2(N_ELEM):0]      addr,
  output logic                         rd,
  input  logic [PIX_W-1:0]             a_data,
  input  logic [PIX_W-1:0]             b_data,
  output logic [SUM_W-1:0]             sad,
  output logic                         done
);
  localparam int IDX_W = $clog2(N_ELEM) + 1;

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_CHECK, S_ACC, S_FIN} state_t;
  state_t state;

  logic [IDX_W-1:0] idx;
  logic [SUM_W-1:0] acc;
  logic [PIX_W:0]   diff;
  logic [PIX_W:0]   mag;

  assign diff = {1'b0, a_data} - {1'b0, b_data};
  assign mag  = diff[PIX_W] ? (~diff + 1'b1) : diff;

  assign addr = idx;
  assign rd   = (state == S_ACC);
  assign done = (state == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      acc   <= '0;
      sad   <= '0;
    end else begin
      case (state)
        S_IDLE:  if (go) state <= S_INIT;
        S_INIT: begin
          idx   <= '0;
          acc   <= '0;
          state <= S_CHECK;
        end
        S_CHECK: state <= (idx < IDX_W'(N_ELEM)) ? S_ACC : S_FIN;
        S_ACC: begin
          acc   <= acc + SUM_W'(mag[PIX_W-1:0]);
          idx   <= idx + 1'b1;
          state <= S_CHECK;
        end
        S_FIN: begin
          sad   <= acc;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module sad_engine_chk #(
  parameter int AW = 9,
  parameter int SW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd,
  input logic [SW-1:0] sad,
  input logic          done
);
  a_r3_rd_not_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !rd);
  a_r3_addr_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (addr == $past(addr) + AW'(1)));
  a_r3_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> !addr[AW-1]);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd);
  a_r6_sad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(sad));
endmodule

bind sad_engine sad_engine_chk #(.AW($clog2(N_ELEM) + 1), .SW(SUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .sad(sad), .done(done)
);

// File: tb/sad_engine_test.sv
`timescale 1ns/1ps
module sad_engine_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        go = 0;
  logic [8:0]  addr;
  logic        rd;
  logic [7:0]  a_data, b_data;
  logic [31:0] sad;
  logic        done;

  logic [7:0] mem_a [256];
  logic [7:0] mem_b [256];
  assign a_data = mem_a[addr[7:0]];
  assign b_data = mem_b[addr[7:0]];

  always #2 clk = ~clk;

  sad_engine uut (.clk(clk), .rst_n(rst_n), .go(go), .addr(addr), .rd(rd),
                  .a_data(a_data), .b_data(b_data), .sad(sad), .done(done));

  int checks = 0, fails = 0;
  logic [31:0] expq[$];
  logic [31:0] prev_sad = 0;
  bit running = 0;
  int cyc = 0;
  int rdcnt = 0;
  bit pending = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin running <= 0; cyc <= 0; end
    else if (running && done) running <= 0;
    else if (!running && go) begin running <= 1; cyc <= 0; end
    else if (running) cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pending) begin
        pending = 0;
        if (expq.size() == 0) chk(0, "R4 unexpected result", sad, 0);
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          chk(sad == e, "R4 sad value", sad, e);
        end
        prev_sad = sad;
      end
      if (rd) begin
        chk(addr == 9'(rdcnt), "R3 address order", addr, rdcnt);
        rdcnt++;
      end
      if (done) begin
        chk(cyc == 514, "R5 latency", cyc + 1, 515);
        chk(rdcnt == 256, "R3 read count", rdcnt, 256);
        chk(sad == prev_sad, "R6 old result during done", sad, prev_sad);
        rdcnt = 0;
        pending = 1;
      end
    end
  end

  function automatic logic [31:0] ref_sad();
    logic [31:0] s = 0;
    for (int i = 0; i < 256; i++)
      s += (mem_a[i] > mem_b[i]) ? 32'(mem_a[i] - mem_b[i]) : 32'(mem_b[i] - mem_a[i]);
    return s;
  endfunction

  task automatic fill(int kind);
    for (int i = 0; i < 256; i++) begin
      case (kind)
        0: begin mem_a[i] = 0; mem_b[i] = 0; end
        1: begin mem_a[i] = 8'hFF; mem_b[i] = 0; end
        2: begin mem_a[i] = 0; mem_b[i] = 8'hFF; end
        3: begin mem_a[i] = 8'(i); mem_b[i] = 8'(255 - i); end
        default: begin mem_a[i] = 8'($urandom); mem_b[i] = 8'($urandom); end
      endcase
    end
  endtask

  task automatic wait_idle();
    while (expq.size() != 0 || pending || running) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(int kind, bit wiggle);
    fill(kind);
    expq.push_back(ref_sad());
    @(negedge clk); go = 1;
    @(negedge clk); go = 0;
    if (wiggle)
      for (int k = 0; k < 400; k++) begin @(negedge clk); go = 1'($urandom); end  // R8
    go = 0;
    wait_idle();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 200000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    chk(sad == 0 && !done && !rd, "R1 reset state", {sad, done, rd}, 0);
    rst_n = 1;
    begin
      bit quiet = 1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (rd || done || sad != 0) quiet = 0;
      end
      chk(quiet, "R2 idle without go", quiet, 1);
    end
    run_case(0, 0);
    run_case(1, 0);
    chk(sad == 32'd65280, "R6 result held after done (R4 max)", sad, 65280);
    run_case(2, 0);
    run_case(3, 0);
    run_case(4, 0);
    run_case(4, 1);  // R8 go toggled during run
    // R7: go held high across two back-to-back comparisons
    fill(4);
    expq.push_back(ref_sad());
    expq.push_back(ref_sad());
    @(negedge clk); go = 1;
    while (!done) @(negedge clk);
    begin
      int gap = 0;
      @(negedge clk);
      while (!done) begin @(negedge clk); gap++; end
      go = 0;
      chk(gap + 1 == 516, "R7 back-to-back period", gap + 1, 516);
    end
    wait_idle();
    chk(expq.size() == 0, "R7 all results seen", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule